// File: doc/BRIEF.md
# Serial Command Decoder with Display RAM

This block is the host-facing front end of a multiplexed LED controller. A host drives a strobe, a shift clock and a data line. While the strobe is low, the block samples one bit on each rising shift-clock edge and builds bytes from the least significant bit up. The first whole byte after each strobe fall is taken as a command. Its two top bits pick one of four command classes: digit-mode selection, data setting, address loading and display control.

The block keeps the configuration that those commands set and drives it to the scan, dimming and key-read logic beside it. Bytes that follow a command in a write frame land in a small display RAM, either at successive addresses or all at one fixed address. The scan logic reads the RAM through its own read port.

All three serial inputs are asynchronous. They pass through flop synchronisers into the system clock domain before any edge is detected. A one-cycle pulse marks each command the block takes and each RAM write it makes.

Top module: `ledc_serial_cmd`

## Requirements
- R1: After reset, digit mode is 3 (7 digits / 11 segments), the dimming code is 0, the display is off, the key-read, fixed-address and test flags are 0, the write address is 0, and every RAM byte reads 0.
- R2: While the strobe is low, a bit is taken on each rising shift-clock edge and the first bit is byte bit 0. The first full byte after a strobe fall is a command. Its bits 7:6 select the class: 00 = digit mode, 01 = data setting, 10 = display control, 11 = address load.
- R3: If the strobe goes high before a byte is complete, the partial bits are dropped. The next frame begins a fresh byte, and that byte is a command.
- R4: A digit-mode command copies bits 1:0 to the digit mode. If the new value differs from the current one, the display is also switched off. If it is the same, nothing changes and the display stays on.
- R5: A data-setting command copies bit 1 to the key-read flag, bit 2 to the fixed-address flag and bit 3 to the test flag.
- R6: A display-control command copies bits 2:0 to the dimming code and bit 3 to the display-on flag.
- R7: An address-load command sets the write address to bits 3:0. In a write frame, each data byte is stored at the current address. With the fixed-address flag at 0, the address then steps up by one.
- R8: With the fixed-address flag at 1, the address does not move, so each further byte overwrites the same RAM location.
- R9: While the address is 14 or more, data bytes are dropped and the RAM is left unchanged. This includes the address reached by stepping past 13. Writing resumes once a valid address is loaded.
- R10: While the key-read flag is 1, data bytes never write the RAM.
- R11: Data bytes in a frame whose command was a digit-mode or display-control command are ignored.
- R12: The command pulse is high for exactly one cycle per command byte. The write pulse is high for exactly one cycle per RAM write. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock from the host (asynchronous) |
| ser_dat_i | input | 1 | Serial data from the host (asynchronous) |
| ser_stb_i | input | 1 | Frame strobe, active low (asynchronous) |
| ram_rd_addr_i | input | 4 | Display RAM read address for the scan logic |
| ram_rd_data_o | output | 8 | Display RAM byte at the read address (0 when the address is out of range) |
| digit_mode_o | output | 2 | Digit/segment mode |
| key_read_o | output | 1 | Key-read mode flag |
| addr_fixed_o | output | 1 | Fixed-address flag |
| test_mode_o | output | 1 | Test mode flag |
| dim_code_o | output | 3 | Dimming code |
| disp_on_o | output | 1 | Display enable |
| cmd_pulse_o | output | 1 | One-cycle pulse per command taken |
| wr_pulse_o | output | 1 | One-cycle pulse per RAM write |

## Verification
The bench drives command frames with every class code and compares the configuration outputs. This shows the class is decoded from the top bits and that the byte is assembled from bit 0 up. Write frames are sent in auto-step mode, in fixed mode, near the top of the address range and at an out-of-range address. Reading the RAM back then tells stepping apart from overwriting, and a dropped byte apart from a stored one. Data bytes are also sent in key-read mode and after digit-mode and display-control commands; the RAM must stay as it was. A digit-mode command is sent twice, once with the mode already in effect and once with a new mode, to show that only a real change turns the display off. Frames cut short mid-byte are followed by a full command, so any partial bits kept over would show up as a wrong dimming code.

// File: rtl/ledc_cmd_pkg.sv
package ledc_cmd_pkg;

   typedef enum logic [1:0] {
      CLS_MODE = 2'b00,
      CLS_DATA = 2'b01,
      CLS_CTRL = 2'b10,
      CLS_ADDR = 2'b11
   } cmd_class_e;

   localparam logic [1:0] DIGIT_MODE_RST = 2'b11;
   localparam logic [2:0] DIM_RST        = 3'b000;

   typedef struct packed {
      logic [1:0] digit_mode;
      logic       key_read;
      logic       addr_fixed;
      logic       test_mode;
      logic [2:0] dim_code;
      logic       disp_on;
   } ledc_cfg_t;

endpackage

// File: rtl/ledc_in_sync.sv
module ledc_in_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] prev_o
);

   logic [W-1:0] stg [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= RST_VAL;
               else        stg[g] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= RST_VAL;
               else        stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o <= RST_VAL;
      else        prev_o <= stg[STAGES-1];
   end

   assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/ledc_byte_rx.sv
module ledc_byte_rx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_rise,
   input  logic              stb_high,
   input  logic              din,
   output logic              byte_vld,
   output logic [DATA_W-1:0] byte_dat,
   output logic              byte_first
);

   localparam int              CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  bit_cnt;
   logic              first_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         bit_cnt    <= '0;
         first_pend <= 1'b1;
         byte_vld   <= 1'b0;
         byte_dat   <= '0;
         byte_first <= 1'b0;
      end else begin
         byte_vld <= 1'b0;
         if (stb_high) begin
            bit_cnt    <= '0;
            first_pend <= 1'b1;
         end else if (sclk_rise) begin
            shreg <= {din, shreg[DATA_W-1:1]};
            if (bit_cnt == LAST) begin
               bit_cnt    <= '0;
               byte_vld   <= 1'b1;
               byte_dat   <= {din, shreg[DATA_W-1:1]};
               byte_first <= first_pend;
               first_pend <= 1'b0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   // R3
   frame_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_high |=> (bit_cnt == '0) && first_pend);

   // R2
   byte_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);

endmodule

// File: rtl/ledc_cmd_decode.sv
module ledc_cmd_decode
   import ledc_cmd_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int RAM_DEPTH = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_high,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_dat,
   input  logic              byte_first,
   output ledc_cfg_t         cfg,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_dat,
   output logic              cmd_pulse
);

   localparam logic [ADDR_W:0] DEPTH_L = RAM_DEPTH[ADDR_W:0];

   cmd_class_e        cls;
   logic [ADDR_W-1:0] addr;
   logic              frame_ok;
   logic              addr_ok;

   assign cls     = cmd_class_e'(byte_dat[DATA_W-1:DATA_W-2]);
   assign addr_ok = {1'b0, addr} < DEPTH_L;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.digit_mode <= DIGIT_MODE_RST;
         cfg.key_read   <= 1'b0;
         cfg.addr_fixed <= 1'b0;
         cfg.test_mode  <= 1'b0;
         cfg.dim_code   <= DIM_RST;
         cfg.disp_on    <= 1'b0;
         addr           <= '0;
         frame_ok       <= 1'b0;
         wr_en          <= 1'b0;
         wr_addr        <= '0;
         wr_dat         <= '0;
         cmd_pulse      <= 1'b0;
      end else begin
         cmd_pulse <= 1'b0;
         wr_en     <= 1'b0;
         if (stb_high) frame_ok <= 1'b0;
         if (byte_vld) begin
            if (byte_first) begin
               cmd_pulse <= 1'b1;
               unique case (cls)
                  CLS_MODE: begin
                     if (byte_dat[1:0] != cfg.digit_mode) begin
                        cfg.digit_mode <= byte_dat[1:0];
                        cfg.disp_on    <= 1'b0;
                     end
                     frame_ok <= 1'b0;
                  end
                  CLS_DATA: begin
                     cfg.key_read   <= byte_dat[1];
                     cfg.addr_fixed <= byte_dat[2];
                     cfg.test_mode  <= byte_dat[3];
                     frame_ok       <= !byte_dat[1];
                  end
                  CLS_CTRL: begin
                     cfg.dim_code <= byte_dat[2:0];
                     cfg.disp_on  <= byte_dat[3];
                     frame_ok     <= 1'b0;
                  end
                  CLS_ADDR: begin
                     addr     <= byte_dat[ADDR_W-1:0];
                     frame_ok <= 1'b1;
                  end
                  default: frame_ok <= 1'b0;
               endcase
            end else if (frame_ok && !cfg.key_read && addr_ok) begin
               wr_en   <= 1'b1;
               wr_addr <= addr;
               wr_dat  <= byte_dat;
               if (!cfg.addr_fixed) addr <= addr + 1'b1;
            end
         end
      end
   end

   // R9
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ({1'b0, wr_addr} < DEPTH_L));

   // R8
   fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cfg.addr_fixed) |-> (addr == wr_addr));

   // R7
   incr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cfg.addr_fixed) |-> (addr == wr_addr + 1'b1));

   // R10
   rd_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.key_read |-> !wr_en);

   // R12
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_pulse && wr_en));

   // R4
   mode_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.digit_mode != $past(cfg.digit_mode)) |-> !cfg.disp_on);

endmodule

// File: rtl/ledc_disp_ram.sv
module ledc_disp_ram #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int RAM_DEPTH = 14,
   parameter bit CLEAR_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_dat,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_dat
);

   logic [DATA_W-1:0] mem [RAM_DEPTH];

   genvar g;
   generate
      for (g = 0; g < RAM_DEPTH; g++) begin : g_cell
         if (CLEAR_RST) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                  mem[g] <= '0;
               else if (wr_en && wr_addr == ADDR_W'(g))     mem[g] <= wr_dat;
            end
         end else begin : g_norst
            always_ff @(posedge clk) begin
               if (wr_en && wr_addr == ADDR_W'(g)) mem[g] <= wr_dat;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_dat = '0;
      for (int i = 0; i < RAM_DEPTH; i++) begin
         if (rd_addr == ADDR_W'(i)) rd_dat = mem[i];
      end
   end

endmodule

// File: rtl/ledc_serial_cmd.sv
module ledc_serial_cmd
   import ledc_cmd_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int RAM_DEPTH   = 14,
   parameter int SYNC_STAGES = 2,
   parameter bit CLEAR_RST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              ser_stb_i,
   input  logic [ADDR_W-1:0] ram_rd_addr_i,
   output logic [DATA_W-1:0] ram_rd_data_o,
   output logic [1:0]        digit_mode_o,
   output logic              key_read_o,
   output logic              addr_fixed_o,
   output logic              test_mode_o,
   output logic [2:0]        dim_code_o,
   output logic              disp_on_o,
   output logic              cmd_pulse_o,
   output logic              wr_pulse_o
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("ledc_serial_cmd: command layout needs DATA_W of 8");
      end
      if (RAM_DEPTH > (1 << ADDR_W) || RAM_DEPTH < 1) begin : g_bad_depth
         $error("ledc_serial_cmd: RAM_DEPTH must fit in ADDR_W bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ledc_serial_cmd: SYNC_STAGES must be at least 2");
      end
   endgenerate

   localparam int SIG_W = 3;
   localparam logic [SIG_W-1:0] SIG_RST = 3'b100;

   logic [SIG_W-1:0] sig_sync, sig_prev;
   logic             sclk_rise, stb_high, din_s;
   logic             byte_vld, byte_first;
   logic [DATA_W-1:0] byte_dat;
   ledc_cfg_t        cfg;
   logic             wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_dat;

   ledc_in_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (SIG_W),
      .RST_VAL (SIG_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({ser_stb_i, ser_dat_i, ser_clk_i}),
      .sync_o  (sig_sync),
      .prev_o  (sig_prev)
   );

   assign sclk_rise = sig_sync[0] && !sig_prev[0];
   assign din_s     = sig_sync[1];
   assign stb_high  = sig_sync[2];

   ledc_byte_rx #(.DATA_W(DATA_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_rise  (sclk_rise),
      .stb_high   (stb_high),
      .din        (din_s),
      .byte_vld   (byte_vld),
      .byte_dat   (byte_dat),
      .byte_first (byte_first)
   );

   ledc_cmd_decode #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .RAM_DEPTH (RAM_DEPTH)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb_high   (stb_high),
      .byte_vld   (byte_vld),
      .byte_dat   (byte_dat),
      .byte_first (byte_first),
      .cfg        (cfg),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_dat     (wr_dat),
      .cmd_pulse  (cmd_pulse_o)
   );

   ledc_disp_ram #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .RAM_DEPTH (RAM_DEPTH),
      .CLEAR_RST (CLEAR_RST)
   ) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_dat  (wr_dat),
      .rd_addr (ram_rd_addr_i),
      .rd_dat  (ram_rd_data_o)
   );

   assign digit_mode_o = cfg.digit_mode;
   assign key_read_o   = cfg.key_read;
   assign addr_fixed_o = cfg.addr_fixed;
   assign test_mode_o  = cfg.test_mode;
   assign dim_code_o   = cfg.dim_code;
   assign disp_on_o    = cfg.disp_on;
   assign wr_pulse_o   = wr_en;

   // R12
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pulse_o |=> !cmd_pulse_o);

endmodule

// File: tb/sim_ledc_serial_cmd.sv
module sim_ledc_serial_cmd;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b1;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [1:0] digit_mode;
   logic       key_read, addr_fixed, test_mode, disp_on, cmd_pulse, wr_pulse;
   logic [2:0] dim_code;

   int total = 0;
   int bad = 0;
   int exp_q[$];
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ledc_serial_cmd u0 (
      .clk (clk), .rst_n (rst_n),
      .ser_clk_i (ser_clk), .ser_dat_i (ser_dat), .ser_stb_i (ser_stb),
      .ram_rd_addr_i (rd_addr), .ram_rd_data_o (rd_data),
      .digit_mode_o (digit_mode), .key_read_o (key_read),
      .addr_fixed_o (addr_fixed), .test_mode_o (test_mode),
      .dim_code_o (dim_code), .disp_on_o (disp_on),
      .cmd_pulse_o (cmd_pulse), .wr_pulse_o (wr_pulse)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_ram(input string req, input int a, input int exp);
      @(negedge clk);
      rd_addr = 4'(a);
      #1;
      chk(req, int'(rd_data), exp);
   endtask

   task automatic put_bit(input logic v);
      ser_dat = v;
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic put_byte(input logic [7:0] b, input int nbits);
      for (int i = 0; i < nbits; i++) put_bit(b[i]);
   endtask

   // frame of n bytes (byte i at fr[8*i +: 8]); nwr = writes expected
   task automatic send_frame(input logic [63:0] fr, input int n, input int nwr);
      exp_q.push_back(0);
      for (int i = 0; i < nwr; i++) exp_q.push_back(1);
      ser_stb = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < n; i++) put_byte(fr[8*i +: 8], 8);
      repeat (4) @(negedge clk);
      ser_stb = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic send_cut(input logic [63:0] fr, input int nfull, input int nbits, input int nwr);
      if (nfull > 0) exp_q.push_back(0);
      for (int i = 0; i < nwr; i++) exp_q.push_back(1);
      ser_stb = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nfull; i++) put_byte(fr[8*i +: 8], 8);
      put_byte(fr[8*nfull +: 8], nbits);
      ser_stb = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   // scoreboard monitor: R12 pulse order and count
   always @(negedge clk) begin
      if (rst_n && (cmd_pulse || wr_pulse)) begin
         total++;
         if (cmd_pulse && wr_pulse) begin
            bad++;
            $display("FAIL R12: actual=both pulses expected=one");
         end else if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R12: actual=pulse kind %0d expected=none", wr_pulse ? 1 : 0);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (e != (wr_pulse ? 1 : 0)) begin
               bad++;
               $display("FAIL R12: actual=kind %0d expected=kind %0d", wr_pulse ? 1 : 0, e);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 digit mode", int'(digit_mode), 3);
      chk("R1 dim", int'(dim_code), 0);
      chk("R1 disp_on", int'(disp_on), 0);
      chk("R1 key_read", int'(key_read), 0);
      chk("R1 addr_fixed", int'(addr_fixed), 0);
      chk("R1 test", int'(test_mode), 0);
      chk_ram("R1 ram", 9, 0);

      // R6 R2 display control class 10
      send_frame(64'h8F, 1, 0);
      chk("R6 dim", int'(dim_code), 7);
      chk("R6 on", int'(disp_on), 1);
      // R4 same mode keeps display on
      send_frame(64'h03, 1, 0);
      chk("R4 same mode", int'(digit_mode), 3);
      chk("R4 same mode on", int'(disp_on), 1);
      // R4 new mode blanks
      send_frame(64'h01, 1, 0);
      chk("R4 new mode", int'(digit_mode), 1);
      chk("R4 new mode off", int'(disp_on), 0);
      send_frame(64'h8A, 1, 0);
      chk("R6 dim 2", int'(dim_code), 2);
      chk("R6 on 2", int'(disp_on), 1);

      // R7 auto-step writes, R2 bit order
      send_frame(64'h40, 1, 0);
      chk("R5 fixed off", int'(addr_fixed), 0);
      send_frame(64'h33_22_11_C0, 4, 3);
      chk_ram("R7 ram0", 0, 8'h11);
      chk_ram("R7 ram1", 1, 8'h22);
      chk_ram("R7 ram2", 2, 8'h33);

      // R8 fixed address
      send_frame(64'h44, 1, 0);
      chk("R5 fixed on", int'(addr_fixed), 1);
      send_frame(64'h5B_AA_C5, 3, 2);
      chk_ram("R8 ram5", 5, 8'h5B);
      chk_ram("R8 ram6", 6, 0);

      // R9 range end and invalid address
      send_frame(64'h40, 1, 0);
      send_frame(64'h03_02_01_CC, 4, 2);
      chk_ram("R9 ram12", 12, 8'h01);
      chk_ram("R9 ram13", 13, 8'h02);
      send_frame(64'h77_CF, 2, 0);
      chk_ram("R9 ram0 kept", 0, 8'h11);
      send_frame(64'h99_C3, 2, 1);
      chk_ram("R9 recover ram3", 3, 8'h99);

      // R10 key-read mode blocks writes
      send_frame(64'h42, 1, 0);
      chk("R5 key_read", int'(key_read), 1);
      send_frame(64'h55_C4, 2, 0);
      chk_ram("R10 ram4", 4, 0);
      send_frame(64'h48, 1, 0);
      chk("R5 test", int'(test_mode), 1);
      chk("R5 key_read off", int'(key_read), 0);

      // R11 data after display control / mode commands ignored
      send_frame(64'h66_8C, 2, 0);
      chk("R6 dim 4", int'(dim_code), 4);
      chk_ram("R11 ram4 ctrl", 4, 0);
      send_frame(64'h67_02, 2, 0);
      chk("R4 mode 2", int'(digit_mode), 2);
      chk("R4 mode 2 off", int'(disp_on), 0);
      chk_ram("R11 ram4 mode", 4, 0);

      // R3 strobe rise mid-byte
      send_frame(64'h40, 1, 0);
      send_cut(64'hFF_C7, 1, 5, 0);
      chk_ram("R3 ram7", 7, 0);
      send_cut(64'hFF, 0, 3, 0);
      send_frame(64'h89, 1, 0);
      chk("R3 dim after cut", int'(dim_code), 1);
      chk("R3 on after cut", int'(disp_on), 1);

      repeat (10) @(negedge clk);
      chk("R12 queue drained", exp_q.size(), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule